// File: doc/BRIEF.md
# Windowed Register File with Bounded Window Pointer

This block holds a processor's general registers in one physical array and exposes them as a sliding 32-register view. A current-window pointer selects the view. Each step of the pointer moves the view by 16 physical registers, so the lower half of one view is the upper half of the next. A call-entry strobe steps the pointer down and a call-return strobe steps it up. Two combinational read ports and one clocked write port take a 5-bit logical register number and reach the physical entry through the pointer.

A limit register sets how far the pointer may travel. It holds a low bound and a high bound. A call-entry strobe taken at the low bound raises an overflow exception, and a call-return strobe taken at the high bound raises an underflow exception. In both cases the pointer stays where it is. The limit register sits at control address 2 and can always be read. A build option decides whether software may rewrite it, for example to split the array between a kernel and a user region. A second build option removes limit checking entirely, and the pointer then wraps freely. Trap sequencing is left to the surrounding pipeline, which consumes the exception outputs and the pointer.

Top module: `win_regfile`

## Requirements
- R1: After reset the low bound is 1, the high bound is (NUM_REGS/16) - 3, the pointer equals the high bound, and both exception outputs are low.
- R2: Logical register r in window c maps to physical entry (16*c + r) mod NUM_REGS. Reads are combinational. A write lands at the clock edge through the pointer value held before that edge, so a same-cycle read returns the old data. After a successful call-entry step, logical r+16 shows what logical r showed before the step.
- R3: When only the call-entry strobe is high: with checking enabled and the pointer equal to the low bound, ovf_exc is high in that cycle and the pointer keeps its value. Otherwise the pointer decreases by one, modulo the window count.
- R4: When only the call-return strobe is high: with checking enabled and the pointer equal to the high bound, unf_exc is high in that cycle and the pointer keeps its value. Otherwise the pointer increases by one, modulo the window count.
- R5: When both strobes are high together, the pointer does not move and no exception is raised.
- R6: With HAS_EXC = 0, neither exception output is ever raised, and the pointer wraps through all windows.
- R7: A control read at address 2 returns the low bound in bits [W-1:0] and the high bound in bits [2W-1:W], where W = log2(NUM_REGS/16), with zeros above. Every other control address reads as zero.
- R8: With WV_WRITE = 1, a control write to address 2 loads both bounds from the same bit fields, and they take effect from the next cycle. A write to any other address changes nothing.
- R9: With WV_WRITE = 0, a control write to address 2 leaves both bounds unchanged.
- R10: cur_win shows the pointer at all times and changes only through R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Logical register for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 5 | Logical register for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register to write |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Call-entry strobe, steps the pointer down |
| restore_req | input | 1 | Call-return strobe, steps the pointer up |
| ctl_rd_addr | input | CTL_AW | Control read address |
| ctl_rd_data | output | DATA_W | Control read data |
| ctl_wr_en | input | 1 | Control write enable |
| ctl_wr_addr | input | CTL_AW | Control write address |
| ctl_wr_data | input | DATA_W | Control write data |
| cur_win | output | log2(NUM_REGS/16) | Current window pointer |
| ovf_exc | output | 1 | Overflow exception |
| unf_exc | output | 1 | Underflow exception |

## Verification
The pointer is first walked all the way down with repeated call-entry strobes and then all the way up with repeated call-return strobes. This separates a correct stop at each bound from an off-by-one and from wrap-around, and a build without limit checks runs the same pattern alongside to show free wrapping. Writes to logical 0 just before each step, read back through logical 16 after it, separate a correct 16-register overlap from any other stride. Paired strobes, limit rewrites with write access on and off, and writes to unrelated control addresses each test a case where state must stay put. A long randomized stream then mixes all of these with reads and writes that hit the same entry in the same cycle.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
  localparam int WIN_STEP = 16;
  localparam int LOG_REGS = 32;
  localparam int WV_ADDR  = 2;

  // number of pointer positions for a given physical size
  function automatic int win_total(input int nregs);
    return nregs / WIN_STEP;
  endfunction

  // pointer value and high bound after reset
  function automatic int reset_top(input int nregs);
    return win_total(nregs) - 3;
  endfunction

  // logical register under a window to physical entry
  function automatic int phys_of(input int cwp, input int lreg, input int nregs);
    return (cwp * WIN_STEP + lreg) % nregs;
  endfunction
endpackage

// File: rtl/rfw_bank.sv
module rfw_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [AW-1:0]                waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]       raddr,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = cells[raddr[p]];
  end
endmodule

// File: rtl/rfw_limits.sv
module rfw_limits #(
  parameter int DATA_W    = 32,
  parameter int CTL_AW    = 4,
  parameter int WIN_W     = 3,
  parameter int RESET_HI  = 5,
  parameter bit WV_WRITE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [CTL_AW-1:0] ctl_wr_addr,
  input  logic [DATA_W-1:0] ctl_wr_data,
  input  logic [CTL_AW-1:0] ctl_rd_addr,
  output logic [DATA_W-1:0] ctl_rd_data,
  output logic [WIN_W-1:0]  lo_lim,
  output logic [WIN_W-1:0]  hi_lim
);
  localparam logic [CTL_AW-1:0] LIM_ADDR = CTL_AW'(rfw_pkg::WV_ADDR);

  logic lim_wr_hit;
  logic unused_upper;

  assign lim_wr_hit   = WV_WRITE && ctl_wr_en && (ctl_wr_addr == LIM_ADDR);
  assign unused_upper = ^ctl_wr_data[DATA_W-1:2*WIN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_lim <= WIN_W'(1);
      hi_lim <= WIN_W'(RESET_HI);
    end else if (lim_wr_hit) begin
      lo_lim <= ctl_wr_data[WIN_W-1:0];
      hi_lim <= ctl_wr_data[2*WIN_W-1:WIN_W];
    end
  end

  always_comb begin
    ctl_rd_data = '0;
    if (ctl_rd_addr == LIM_ADDR) ctl_rd_data = DATA_W'({hi_lim, lo_lim});
  end
endmodule

// File: rtl/rfw_pointer.sv
module rfw_pointer #(
  parameter int WIN_W     = 3,
  parameter int RESET_CWP = 5,
  parameter bit HAS_EXC   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [WIN_W-1:0] lo_lim,
  input  logic [WIN_W-1:0] hi_lim,
  output logic [WIN_W-1:0] cwp,
  output logic             ovf,
  output logic             unf
);
  logic lone_save, lone_rest, step_dn, step_up;

  assign lone_save = save_req & ~restore_req;
  assign lone_rest = restore_req & ~save_req;
  assign ovf       = HAS_EXC && lone_save && (cwp == lo_lim);
  assign unf       = HAS_EXC && lone_rest && (cwp == hi_lim);
  assign step_dn   = lone_save & ~ovf;
  assign step_up   = lone_rest & ~unf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cwp <= WIN_W'(RESET_CWP);
    else if (step_dn) cwp <= cwp - 1'b1;
    else if (step_up) cwp <= cwp + 1'b1;
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 32,
  parameter int CTL_AW   = 4,
  parameter bit HAS_EXC  = 1'b1,
  parameter bit WV_WRITE = 1'b1,
  localparam int WIN_W   = $clog2(NUM_REGS / rfw_pkg::WIN_STEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [4:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic [CTL_AW-1:0] ctl_rd_addr,
  output logic [DATA_W-1:0] ctl_rd_data,
  input  logic              ctl_wr_en,
  input  logic [CTL_AW-1:0] ctl_wr_addr,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [WIN_W-1:0]  cur_win,
  output logic              ovf_exc,
  output logic              unf_exc
);
  localparam int PHY_W    = $clog2(NUM_REGS);
  localparam int RESET_HI = rfw_pkg::reset_top(NUM_REGS);

  logic [WIN_W-1:0]             lo_lim, hi_lim;
  logic [PHY_W-1:0]             wr_phys;
  logic [1:0][PHY_W-1:0]        rd_phys;
  logic [1:0][DATA_W-1:0]       rd_vals;

  rfw_limits #(
    .DATA_W(DATA_W), .CTL_AW(CTL_AW), .WIN_W(WIN_W),
    .RESET_HI(RESET_HI), .WV_WRITE(WV_WRITE)
  ) u_lim (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_addr(ctl_wr_addr), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_addr(ctl_rd_addr), .ctl_rd_data(ctl_rd_data),
    .lo_lim(lo_lim), .hi_lim(hi_lim)
  );

  rfw_pointer #(
    .WIN_W(WIN_W), .RESET_CWP(RESET_HI), .HAS_EXC(HAS_EXC)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req),
    .lo_lim(lo_lim), .hi_lim(hi_lim),
    .cwp(cur_win), .ovf(ovf_exc), .unf(unf_exc)
  );

  assign wr_phys    = PHY_W'(rfw_pkg::phys_of(int'(cur_win), int'(wr_idx), NUM_REGS));
  assign rd_phys[0] = PHY_W'(rfw_pkg::phys_of(int'(cur_win), int'(rd_a_idx), NUM_REGS));
  assign rd_phys[1] = PHY_W'(rfw_pkg::phys_of(int'(cur_win), int'(rd_b_idx), NUM_REGS));

  rfw_bank #(
    .DATA_W(DATA_W), .DEPTH(NUM_REGS), .NRD(2)
  ) u_bank (
    .clk(clk), .we(wr_en), .waddr(wr_phys), .wdata(wr_data),
    .raddr(rd_phys), .rdata(rd_vals)
  );

  assign rd_a_data = rd_vals[0];
  assign rd_b_data = rd_vals[1];
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int WIN_W    = 3,
  parameter bit HAS_EXC  = 1'b1,
  parameter bit WV_WRITE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             save_req,
  input logic             restore_req,
  input logic [WIN_W-1:0] cur_win,
  input logic             ovf_exc,
  input logic             unf_exc,
  input logic [WIN_W-1:0] lo_lim,
  input logic [WIN_W-1:0] hi_lim
);
  assert_ovf_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |=> $stable(cur_win));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |-> (save_req && !restore_req));

  assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && !ovf_exc) |=> (cur_win == $past(cur_win) - 1'b1));

  assert_unf_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_exc |=> $stable(cur_win));

  assert_restore_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !unf_exc) |=> (cur_win == $past(cur_win) + 1'b1));

  assert_pair_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> $stable(cur_win));

  assert_pair_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |-> !(ovf_exc || unf_exc));

  assert_no_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_exc || unf_exc) |-> HAS_EXC);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req) |=> $stable(cur_win));

  assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !WV_WRITE |=> ($stable(lo_lim) && $stable(hi_lim)));
endmodule

bind win_regfile win_regfile_chk #(
  .WIN_W(WIN_W), .HAS_EXC(HAS_EXC), .WV_WRITE(WV_WRITE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
  .cur_win(cur_win), .ovf_exc(ovf_exc), .unf_exc(unf_exc),
  .lo_lim(lo_lim), .hi_lim(hi_lim)
);

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int CLK_P = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        save, restore, we, cwe;
  logic [4:0]  widx, ra, rb;
  logic [31:0] wd, cwd;
  logic [3:0]  cwa, cra;

  logic [31:0] rda_a, rdb_a, ctl_a, rda_b, rdb_b, ctl_b;
  logic [2:0]  cw_a;
  logic [3:0]  cw_b;
  logic        ovf_a, unf_a, ovf_b, unf_b;

  int total = 0, bad = 0;
  bit done = 0;

  // model state, index 0: default build, index 1: 256 entries, no checks, locked limits
  int          cwp[2], lo[2], hi[2];
  int          nw[2]   = '{8, 16};
  int          ww[2]   = '{3, 4};
  int          nr[2]   = '{128, 256};
  bit          exon[2] = '{1'b1, 1'b0};
  bit          wron[2] = '{1'b1, 1'b0};
  logic [31:0] mem[2][512];
  bit          known[2][512];

  always #(CLK_P/2) clk = ~clk;

  win_regfile i_win_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ra), .rd_a_data(rda_a), .rd_b_idx(rb), .rd_b_data(rdb_a),
    .wr_en(we), .wr_idx(widx), .wr_data(wd),
    .save_req(save), .restore_req(restore),
    .ctl_rd_addr(cra), .ctl_rd_data(ctl_a),
    .ctl_wr_en(cwe), .ctl_wr_addr(cwa), .ctl_wr_data(cwd),
    .cur_win(cw_a), .ovf_exc(ovf_a), .unf_exc(unf_a)
  );

  win_regfile #(.NUM_REGS(256), .HAS_EXC(1'b0), .WV_WRITE(1'b0)) i_win_regfile_b (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ra), .rd_a_data(rda_b), .rd_b_idx(rb), .rd_b_data(rdb_b),
    .wr_en(we), .wr_idx(widx), .wr_data(wd),
    .save_req(save), .restore_req(restore),
    .ctl_rd_addr(cra), .ctl_rd_data(ctl_b),
    .ctl_wr_en(cwe), .ctl_wr_addr(cwa), .ctl_wr_data(cwd),
    .cur_win(cw_b), .ovf_exc(ovf_b), .unf_exc(unf_b)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int phys(input int k, input int c, input int r);
    return (c * 16 + r) % nr[k];
  endfunction

  function automatic longint lim_word(input int k);
    return longint'((hi[k] << ww[k]) | lo[k]);
  endfunction

  task automatic idle();
    save = 0; restore = 0; we = 0; cwe = 0;
    widx = 0; wd = 0; cwd = 0; cwa = 0; cra = 4'd2; ra = 0; rb = 0;
  endtask

  // compare every output against the model, then advance the model across the edge
  task automatic tick();
    int  act_cw, pa, pb, nlo, nhi;
    bit  ls, lr, e_ovf, e_unf, act_ovf, act_unf;
    logic [31:0] ada, adb, actl;
    string tag;
    #(CLK_P/4);
    ls = save && !restore;
    lr = restore && !save;
    for (int k = 0; k < 2; k++) begin
      act_cw  = (k == 0) ? int'(cw_a) : int'(cw_b);
      act_ovf = (k == 0) ? ovf_a : ovf_b;
      act_unf = (k == 0) ? unf_a : unf_b;
      ada     = (k == 0) ? rda_a : rda_b;
      adb     = (k == 0) ? rdb_a : rdb_b;
      actl    = (k == 0) ? ctl_a : ctl_b;
      e_ovf = exon[k] && ls && (cwp[k] == lo[k]);
      e_unf = exon[k] && lr && (cwp[k] == hi[k]);
      tag = ls ? "R3" : (lr ? "R4" : ((save && restore) ? "R5" : "R10"));
      chk(act_cw == cwp[k], tag, act_cw, cwp[k]);
      chk(act_ovf == e_ovf, exon[k] ? "R3" : "R6", act_ovf, e_ovf);
      chk(act_unf == e_unf, exon[k] ? "R4" : "R6", act_unf, e_unf);
      pa = phys(k, cwp[k], int'(ra));
      pb = phys(k, cwp[k], int'(rb));
      if (known[k][pa]) chk(ada == mem[k][pa], "R2", ada, mem[k][pa]);
      if (known[k][pb]) chk(adb == mem[k][pb], "R2", adb, mem[k][pb]);
      chk(longint'(actl) == ((cra == 4'd2) ? lim_word(k) : 0), "R7", actl,
          (cra == 4'd2) ? lim_word(k) : 0);
      // model update
      if (we) begin
        mem[k][phys(k, cwp[k], int'(widx))] = wd;
        known[k][phys(k, cwp[k], int'(widx))] = 1'b1;
      end
      if (ls && !e_ovf) cwp[k] = (cwp[k] + nw[k] - 1) % nw[k];
      if (lr && !e_unf) cwp[k] = (cwp[k] + 1) % nw[k];
      if (cwe && cwa == 4'd2 && wron[k]) begin
        nlo = int'(cwd) & ((1 << ww[k]) - 1);
        nhi = (int'(cwd) >> ww[k]) & ((1 << ww[k]) - 1);
        lo[k] = nlo;
        hi[k] = nhi;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(longint'(CLK_P) * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      lo[k] = 1; hi[k] = nw[k] - 3; cwp[k] = hi[k];
      for (int i = 0; i < 512; i++) known[k][i] = 1'b0;
    end
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_P/4);
    // R1: reset state
    chk(cw_a == 3'd5, "R1", cw_a, 5);
    chk(cw_b == 4'd13, "R1", cw_b, 13);
    chk(!ovf_a && !unf_a, "R1", {ovf_a, unf_a}, 0);
    chk(ctl_a == 32'h29, "R1", ctl_a, 32'h29);
    chk(ctl_b == 32'hD1, "R1", ctl_b, 32'hD1);
    @(negedge clk);

    // fill the current view, reading back the previous entry each cycle
    for (int r = 0; r < 32; r++) begin
      idle(); we = 1; widx = 5'(r); wd = 32'hA000 + r;
      ra = 5'(r); rb = 5'((r + 31) % 32);
      tick();
    end

    // walk down: write logical 0, step, read it back as logical 16 (R2 overlap)
    for (int s = 0; s < 7; s++) begin
      idle(); we = 1; widx = 0; wd = 32'hB000 + s; rb = 5'd16;
      tick();
      idle(); save = 1; rb = 5'd16; ra = 0;
      tick();
      idle(); rb = 5'd16;
      tick();
    end
    chk(cw_a == 3'd1, "R3", cw_a, 1);

    // walk up past the high bound
    for (int s = 0; s < 10; s++) begin
      idle(); restore = 1; ra = 5'd16; rb = 0;
      tick();
    end
    chk(cw_a == 3'd5, "R4", cw_a, 5);

    // paired strobes
    for (int s = 0; s < 3; s++) begin
      idle(); save = 1; restore = 1;
      tick();
    end

    // rewrite the limits: hi=3, lo=2 in the 3-bit field layout
    idle(); cwe = 1; cwa = 4'd2; cwd = 32'h1A;
    tick();
    idle(); cra = 4'd2;
    #(CLK_P/4);
    chk(ctl_a == 32'h1A, "R8", ctl_a, 32'h1A);
    chk(ctl_b == 32'hD1, "R9", ctl_b, 32'hD1);
    @(negedge clk);
    idle(); cwe = 1; cwa = 4'd5; cwd = 32'h3F;
    tick();
    idle(); cra = 4'd2;
    #(CLK_P/4);
    chk(ctl_a == 32'h1A, "R8", ctl_a, 32'h1A);
    @(negedge clk);
    idle(); cra = 4'd5;
    tick();

    // pointer is 5, above the new high bound of 3: walk down under the new bounds
    for (int s = 0; s < 5; s++) begin
      idle(); save = 1;
      tick();
    end
    chk(cw_a == 3'd2, "R3", cw_a, 2);
    for (int s = 0; s < 3; s++) begin
      idle(); restore = 1;
      tick();
    end
    chk(cw_a == 3'd3, "R4", cw_a, 3);

    // restore full bounds, then a mixed random stream
    idle(); cwe = 1; cwa = 4'd2; cwd = 32'h29;
    tick();
    for (int n = 0; n < 3000; n++) begin
      int sel;
      idle();
      sel = $urandom_range(0, 15);
      save = (sel < 5);
      restore = (sel >= 4 && sel < 9);
      we = $urandom_range(0, 1);
      widx = 5'($urandom_range(0, 31));
      wd = $urandom;
      ra = (n % 5 == 0) ? widx : 5'($urandom_range(0, 31));
      rb = 5'($urandom_range(0, 31));
      cra = 4'($urandom_range(0, 7));
      if ($urandom_range(0, 31) == 0) begin
        cwe = 1;
        cwa = ($urandom_range(0, 1) == 0) ? 4'd2 : 4'($urandom_range(0, 15));
        cwd = ($urandom_range(0, 1) == 0) ? 32'h29 : $urandom;
      end
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule